// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block drives one transmit chain of a DMA engine. Software lays out a ring of 8-byte descriptors in memory, puts a fixed-link entry for the chain into a base-address table, and pulses a trigger. The walker then fetches descriptors one at a time. Link descriptors redirect it to a new 40-bit address. Single-frame descriptors produce one (pointer, length) request to a data mover. When the mover acknowledges, the walker rewrites the descriptor's type byte so that polling software sees the frame as done.

The walk halts on an empty descriptor, on an end-of-set descriptor, or on any type code it does not handle. It keeps the address of the descriptor that halted it. A later trigger resumes from that address, so software only has to re-arm that slot and pulse the trigger again. The base table is read only on the first trigger after reset. The ring closes on itself because its last descriptor is a fixed link back to its first.

Top module: `txd_chain_walker`

## Requirements
- R1: After reset the block issues no memory read, no memory write and no transfer request until the trigger is pulsed.
- R2: Each descriptor is fetched as one 64-bit read, and its data is taken from mem_rdata in the cycle after mem_rd. The fields are laid out as follows: bits [15:0] hold the size field, bits [23:16] the type byte (bits [23:20] the type code, bit 19 interrupt enable), bits [31:24] the upper pointer byte, and bits [63:32] the lower pointer word. The pointer is {bits[31:24], bits[63:32]}.
- R3: The first trigger after reset fetches the chain's base-table entry at tbl_base + 8*CHAIN_SEL.
- R4: A descriptor with type code 0x0 (fixed link) or 0xE (link) makes the next fetch use its pointer. After a completed single-frame descriptor, the next fetch is at the descriptor's address + 8.
- R5: A descriptor with type code 0x8 (single frame) and a non-zero length size[11:0] raises xfer_req carrying the pointer and that length. The request and its values stay steady until xfer_ack.
- R6: A single-frame descriptor is completed by one write to its own address with mem_be = 8'h04, which changes only byte 2. The new type byte is 0x40 with the old bit 3 kept. A zero length completes the descriptor this way without a transfer request.
- R7: Type codes 0xC and 0xD (empty), 0xF (end of set) and every code not named in R4 or R5 halt the walk. The next trigger resumes by fetching the same descriptor again.
- R8: A trigger pulsed while a walk is in progress is remembered. Once the walk halts, the walker at once fetches the halting descriptor again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start pulse for this chain |
| tbl_base | input | 40 | Base-address table location |
| mem_rd | output | 1 | Descriptor read strobe |
| mem_wr | output | 1 | Descriptor write-back strobe |
| mem_addr | output | 40 | Descriptor address |
| mem_be | output | 8 | Byte enables for the write-back |
| mem_wdata | output | 64 | Write-back data |
| mem_rdata | input | 64 | Read data, valid the cycle after mem_rd |
| xfer_req | output | 1 | Request to the data mover |
| xfer_addr | output | 40 | Frame buffer pointer |
| xfer_len | output | 12 | Frame length in bytes |
| xfer_ack | input | 1 | Data mover accepted the request |

## Verification
A trigger arriving while a walk is still running, and the halt that ends that walk, meet in a single state decision. The walker must halt and restart in the same step, not lose the trigger. The bench provokes this by holding a transfer with a long acknowledge delay and pulsing the trigger during that delay. It then judges the result by the halting descriptor's address appearing twice in the fetch log, with no extra transfers and no extra writes. Random rings that mix frames, zero lengths, forward links, empty slots and unknown codes are walked by a reference model in the bench. The transfers and the final memory image are compared word for word.

// File: rtl/txd_chain_walker.sv
module txd_chain_walker #(
  parameter int CHAIN_SEL = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kick,
  input  logic [39:0] tbl_base,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [39:0] mem_addr,
  output logic [7:0]  mem_be,
  output logic [63:0] mem_wdata,
  input  logic [63:0] mem_rdata,
  output logic        xfer_req,
  output logic [39:0] xfer_addr,
  output logic [11:0] xfer_len,
  input  logic        xfer_ack
);
  localparam logic [39:0] TBL_OFS = 40'(CHAIN_SEL * 8);
  localparam logic [39:0] STEP    = 40'd8;

  typedef enum logic [2:0] {IDLE, FETCH, DECODE, MOVE, RETIRE} st_t;

  st_t         st;
  logic [39:0] cur;
  logic [39:0] dptr;
  logic [11:0] dlen;
  logic        ddie;
  logic        started;
  logic        pend;

  wire [3:0]  code   = mem_rdata[23:20];
  wire [39:0] rd_ptr = {mem_rdata[31:24], mem_rdata[63:32]};
  wire [11:0] rd_len = mem_rdata[11:0];
  wire        go     = kick | pend;

  logic unused_bits;
  assign unused_bits = ^{mem_rdata[18:16], mem_rdata[15:12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      cur     <= '0;
      dptr    <= '0;
      dlen    <= '0;
      ddie    <= 1'b0;
      started <= 1'b0;
      pend    <= 1'b0;
    end else begin
      case (st)
        IDLE: if (go) begin
          pend <= 1'b0;
          st   <= FETCH;
          if (!started) begin
            cur     <= tbl_base + TBL_OFS;
            started <= 1'b1;
          end
        end
        FETCH: st <= DECODE;
        DECODE: begin
          dptr <= rd_ptr;
          dlen <= rd_len;
          ddie <= mem_rdata[19];
          case (code)
            4'h0, 4'hE: begin
              cur <= rd_ptr;
              st  <= FETCH;
            end
            4'h8:    st <= (rd_len == 12'd0) ? RETIRE : MOVE;
            default: st <= IDLE;
          endcase
        end
        MOVE: if (xfer_ack) st <= RETIRE;
        RETIRE: begin
          cur <= cur + STEP;
          st  <= FETCH;
        end
        default: st <= IDLE;
      endcase
      if (kick && st != IDLE) pend <= 1'b1;
    end
  end

  assign mem_rd    = (st == FETCH);
  assign mem_wr    = (st == RETIRE);
  assign mem_addr  = cur;
  assign mem_be    = mem_wr ? 8'h04 : 8'h00;
  assign mem_wdata = {40'd0, 4'h4, ddie, 3'b000, 16'd0};
  assign xfer_req  = (st == MOVE);
  assign xfer_addr = dptr;
  assign xfer_len  = dlen;
endmodule

// File: rtl/txd_chain_walker_chk.sv
module txd_chain_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [39:0] mem_addr,
  input logic [7:0]  mem_be,
  input logic [63:0] mem_wdata,
  input logic        xfer_req,
  input logic [39:0] xfer_addr,
  input logic [11:0] xfer_len,
  input logic        xfer_ack
);
  p_read_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd && !mem_wr && !xfer_req);

  p_retire_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> mem_rd && (mem_addr == $past(mem_addr) + 40'd8));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len));

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> xfer_len != 12'd0);

  p_ack_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_ack |=> mem_wr);

  p_wb_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_be == 8'h04 && mem_wdata[23:20] == 4'h4 && !mem_rd);
endmodule

bind txd_chain_walker txd_chain_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
  .xfer_ack(xfer_ack)
);

// File: tb/txd_chain_walker_tb.sv
module txd_chain_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic [39:0] tbl_base = 40'h700;
  logic        mem_rd, mem_wr, xfer_req;
  logic [39:0] mem_addr, xfer_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic [11:0] xfer_len;
  logic        xfer_ack = 1'b0;

  always #2 clk = ~clk;

  txd_chain_walker #(.CHAIN_SEL(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .tbl_base(tbl_base),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_ack(xfer_ack)
  );

  logic [63:0] mem [256];
  logic [63:0] ref_mem [256];
  logic [39:0] got_addr[$], exp_addr[$], rd_log[$];
  logic [11:0] got_len[$], exp_len[$];
  int checks = 0, bad = 0, cur_delay = 0, wcnt = 0;
  localparam logic [39:0] RING = 40'h100;
  localparam logic [63:0] EOS_W = 64'h0000_0000_00F0_0000;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[10:3]];
    if (mem_wr)
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mem[mem_addr[10:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      xfer_ack <= 1'b0;
      wcnt <= 0;
    end else if (xfer_req && !xfer_ack) begin
      if (wcnt >= cur_delay) begin
        xfer_ack <= 1'b1;
        got_addr.push_back(xfer_addr);
        got_len.push_back(xfer_len);
        wcnt <= 0;
      end else wcnt <= wcnt + 1;
    end else xfer_ack <= 1'b0;
  end

  always @(negedge clk) if (rst_n && mem_rd) rd_log.push_back(mem_addr);

  function automatic logic [63:0] mk(input logic [7:0] t, input logic [15:0] sz,
                                     input logic [39:0] p);
    return {p[31:0], p[39:32], t, sz};
  endfunction

  task automatic put(input int idx, input logic [63:0] w);
    mem[idx] = w;
    ref_mem[idx] = w;
  endtask

  task automatic slot(input int s, input logic [63:0] w);
    put(int'(RING[10:3]) + s, w);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_walk(input logic [39:0] start, output logic [39:0] stop);
    logic [39:0] a;
    logic [63:0] d;
    a = start;
    stop = start;
    for (int n = 0; n < 600; n++) begin
      d = ref_mem[a[10:3]];
      case (d[23:20])
        4'h0, 4'hE: a = {d[31:24], d[63:32]};
        4'h8: begin
          if (d[11:0] != 12'd0) begin
            exp_addr.push_back({d[31:24], d[63:32]});
            exp_len.push_back(d[11:0]);
          end
          ref_mem[a[10:3]][23:16] = {4'h4, d[19], 3'b000};
          a = a + 40'd8;
        end
        default: begin
          stop = a;
          return;
        end
      endcase
    end
  endtask

  task automatic pulse;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  task automatic wait_quiet;
    int q = 0;
    while (q < 20) begin
      @(negedge clk);
      if (mem_rd || mem_wr || xfer_req) q = 0;
      else q++;
    end
  endtask

  task automatic compare(input string tag);
    int miss = 0;
    chk(got_addr.size() == exp_addr.size(), {"R5 transfer count ", tag},
        64'(got_addr.size()), 64'(exp_addr.size()));
    for (int i = 0; i < exp_addr.size() && i < got_addr.size(); i++) begin
      chk(got_addr[i] == exp_addr[i], {"R2 pointer ", tag}, 64'(got_addr[i]), 64'(exp_addr[i]));
      chk(got_len[i] == exp_len[i], {"R5 length ", tag}, 64'(got_len[i]), 64'(exp_len[i]));
    end
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) miss++;
    chk(miss == 0, {"R6 memory image ", tag}, 64'(miss), 64'd0);
    got_addr.delete(); got_len.delete(); exp_addr.delete(); exp_len.delete();
  endtask

  function automatic int count_rd(input logic [39:0] a);
    int n = 0;
    foreach (rd_log[i]) if (rd_log[i] == a) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [39:0] resume, stop;
    void'($urandom(32'd7151));
    for (int i = 0; i < 256; i++) put(i, EOS_W);
    put(8'hE0, EOS_W);
    put(8'hE1, mk(8'h00, 16'd0, RING));
    slot(7, mk(8'h00, 16'd0, RING));
    repeat (4) @(negedge clk);
    chk(!mem_rd && !mem_wr && !xfer_req, "R1 in reset", {mem_rd, mem_wr, xfer_req}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!mem_rd && !mem_wr && !xfer_req, "R1 idle after reset",
        {mem_rd, mem_wr, xfer_req}, 0);

    slot(0, mk(8'h80, 16'd64, 40'h5A_0000_1000));
    slot(1, mk(8'h80, 16'd0, 40'h12_3456_7890));
    slot(2, mk(8'h88, 16'hF0FF, 40'h01_CAFE_0000));
    slot(3, mk(8'hC0, 16'd0, 40'd0));
    rd_log.delete();
    pulse();
    wait_quiet();
    ref_walk(40'h708, stop);
    chk(rd_log.size() > 0 && rd_log[0] == 40'h708, "R3 table entry fetch",
        rd_log.size() > 0 ? 64'(rd_log[0]) : 64'd0, 64'h708);
    chk(mem[int'(RING[10:3]) + 2][23:16] == 8'h48, "R6 enable bit kept",
        64'(mem[int'(RING[10:3]) + 2][23:16]), 64'h48);
    compare("directed A");
    resume = stop;

    slot(3, mk(8'h80, 16'd7, 40'h00_0000_2000));
    slot(4, EOS_W);
    rd_log.delete();
    pulse();
    wait_quiet();
    chk(rd_log.size() > 0 && rd_log[0] == resume, "R7 resume at empty",
        rd_log.size() > 0 ? 64'(rd_log[0]) : 64'd0, 64'(resume));
    ref_walk(resume, stop);
    chk(stop == RING + 40'h20, "R7 end of set stop", 64'(stop), 64'(RING + 40'h20));
    compare("directed B");
    resume = stop;

    slot(4, mk(8'h80, 16'd11, 40'h00_0000_3000));
    slot(5, mk(8'h80, 16'd12, 40'h00_0000_3100));
    slot(6, mk(8'h80, 16'd13, 40'h00_0000_3200));
    slot(0, mk(8'h80, 16'd14, 40'h00_0000_3300));
    slot(1, mk(8'hD0, 16'd0, 40'd0));
    rd_log.delete();
    cur_delay = 2;
    pulse();
    wait_quiet();
    ref_walk(resume, stop);
    chk(count_rd(RING + 40'h38) == 1, "R4 ring wrap link", 64'(count_rd(RING + 40'h38)), 64'd1);
    compare("wrap C");
    resume = stop;

    slot(1, mk(8'h80, 16'd32, 40'h00_0000_4000));
    slot(2, EOS_W);
    rd_log.delete();
    cur_delay = 12;
    pulse();
    while (!xfer_req) @(negedge clk);
    pulse();
    wait_quiet();
    ref_walk(resume, stop);
    ref_walk(stop, stop);
    chk(count_rd(stop) == 2, "R8 remembered trigger", 64'(count_rd(stop)), 64'd2);
    compare("pending D");
    resume = stop;

    for (int r = 0; r < 25; r++) begin
      for (int s = 0; s < 7; s++) begin
        int k = $urandom_range(0, 9);
        logic [7:0] die = $urandom_range(0, 1) ? 8'h08 : 8'h00;
        logic [39:0] p = {8'($urandom), 32'($urandom)};
        if (s == 6 && k == 8) k = 0;
        case (k)
          0, 1, 2, 3, 4: slot(s, mk(8'h80 | die, 16'($urandom), p));
          5: slot(s, mk(8'h80 | die, 16'hF000, p));
          6: slot(s, mk($urandom_range(0, 1) ? 8'hC0 : 8'hD0, 16'd0, p));
          7: slot(s, EOS_W);
          8: slot(s, mk(8'hE0, 16'd0,
                        RING + 40'(8 * $urandom_range(s + 1, 6))));
          default: slot(s, mk(8'h90, 16'd5, p));
        endcase
      end
      cur_delay = $urandom_range(0, 3);
      rd_log.delete();
      pulse();
      wait_quiet();
      chk(rd_log.size() > 0 && rd_log[0] == resume, "R7 random resume",
          rd_log.size() > 0 ? 64'(rd_log[0]) : 64'd0, 64'(resume));
      ref_walk(resume, stop);
      compare("random");
      resume = stop;
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule